// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block works beside the opcode fetch of an 8-bit processor with a 16-bit address space. Once an opcode has been fetched and decoded, the decoder pulses `start` and supplies the addressing mode. The program counter it supplies already points one past the opcode. The block also receives the index register and, for branches, the branch-taken outcome. The sequencer reads any operand bytes over a byte-wide synchronous port to program memory. It then produces the operand effective address and the program counter of the next instruction, and marks them valid with a single-cycle `done` pulse.

Four modes are handled: indexed with no offset, indexed with an unsigned byte offset, indexed with a 16-bit offset that arrives most significant byte first, and branch-relative with a signed byte displacement. In every indexed mode the index register is treated as an unsigned value. All 16-bit sums wrap, and no carry or overflow flag is produced.

Top module: `ea_sequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `done`, `mem_rd`, `ea_out` and `npc_out` are all zero.
- R2: Mode code 2'b00 (indexed, no offset) reads no memory. `ea_out` is {8'h00, index}, which is never above 16'h00FF, and `npc_out` equals the accepted program counter. `done` rises one cycle after the edge that accepts `start`.
- R3: Mode code 2'b01 (indexed, byte offset) reads one byte at the program counter. `ea_out` is the zero-extended sum of index and that byte, never above 16'h01FE, and `npc_out` is the program counter plus 1. `done` rises two cycles after the accepting edge.
- R4: Mode code 2'b10 (indexed, 16-bit offset) reads the program counter address and then the following address. The first byte is the upper half of the offset. `ea_out` is (offset + index) mod 2^16, `npc_out` is the program counter plus 2, and `done` rises three cycles after the accepting edge.
- R5: Mode code 2'b11 (relative) reads one byte at the program counter. It computes target = (pc + 1 + sign-extended byte) mod 2^16 and drives it on `ea_out`. `npc_out` is the target when `taken_in` was high at start, otherwise pc + 1. `done` rises two cycles after the accepting edge.
- R6: Each operand byte costs exactly one cycle with `mem_rd` high, at consecutive ascending addresses. Read data is used in the cycle after the read, and no read occurs in the `done` cycle or the cycle before it.
- R7: `done` is high for exactly one cycle per operation. `ea_out` and `npc_out` keep their values until the next `done`.
- R8: A `start` that arrives while an operation is in progress is ignored, together with the mode, program counter, index and taken inputs that come with it.
- R9: Raising `rst` during an operation abandons it: no `done` follows and the outputs return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode | input | 2 | Addressing mode code |
| pc_in | input | 16 | Address of the first byte after the opcode |
| index_in | input | 8 | Index register value |
| taken_in | input | 1 | Branch condition outcome (relative mode) |
| mem_rd | output | 1 | Program memory read strobe |
| mem_addr | output | 16 | Program memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| ea_out | output | 16 | Effective address / branch target |
| npc_out | output | 16 | Next program counter |
| done | output | 1 | Results valid (one-cycle pulse) |

## Verification
A wrong state transition shows up within one to three cycles of `start` as a `done` pulse at the wrong latency. It can also show up as a read strobe count that does not match the operand length. A fetch pointer that advances wrongly presents a wrong address on `mem_addr` during the second read, and the offset halves then assemble in the wrong order. The resulting `ea_out` is wrong in the very cycle `done` rises. Latched inputs that are overwritten by a start arriving mid-operation corrupt the result seen at that same `done`.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [1:0] {
        MODE_IX0  = 2'd0,
        MODE_IX8  = 2'd1,
        MODE_IX16 = 2'd2,
        MODE_REL  = 2'd3
    } ea_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD_A = 2'd1,
        ST_RD_B = 2'd2,
        ST_LAST = 2'd3
    } ea_state_e;

    // Number of operand bytes that follow the opcode for each mode.
    function automatic logic [1:0] operand_bytes(ea_mode_e m);
        case (m)
            MODE_IX0:  operand_bytes = 2'd0;
            MODE_IX16: operand_bytes = 2'd2;
            default:   operand_bytes = 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/ea_fetch_fsm.sv
module ea_fetch_fsm
    import ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  ea_mode_e          mode,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] index_in,
    input  logic              taken_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              finish,
    output ea_mode_e          lat_mode,
    output logic [ADDR_W-1:0] lat_pc,
    output logic [DATA_W-1:0] lat_idx,
    output logic              lat_taken,
    output logic [DATA_W-1:0] hi_byte
);

    typedef struct packed {
        ea_state_e         state;
        ea_mode_e          mode;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] idx;
        logic              taken;
        logic [ADDR_W-1:0] ptr;
        logic [DATA_W-1:0] hi;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d      = q;
        mem_rd = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.mode  = mode;
                    d.pc    = pc_in;
                    d.idx   = index_in;
                    d.taken = taken_in;
                    d.ptr   = pc_in;
                    d.state = (mode == MODE_IX0) ? ST_LAST : ST_RD_A;
                end
            end
            ST_RD_A: begin
                mem_rd  = 1'b1;
                d.ptr   = q.ptr + ADDR_W'(1);
                d.state = (q.mode == MODE_IX16) ? ST_RD_B : ST_LAST;
            end
            ST_RD_B: begin
                mem_rd  = 1'b1;
                d.hi    = mem_rdata;
                d.ptr   = q.ptr + ADDR_W'(1);
                d.state = ST_LAST;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state <= ST_IDLE;
            q.mode  <= MODE_IX0;
            q.pc    <= '0;
            q.idx   <= '0;
            q.taken <= 1'b0;
            q.ptr   <= '0;
            q.hi    <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr  = q.ptr;
    assign finish    = (q.state == ST_LAST);
    assign lat_mode  = q.mode;
    assign lat_pc    = q.pc;
    assign lat_idx   = q.idx;
    assign lat_taken = q.taken;
    assign hi_byte   = q.hi;

endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  ea_mode_e          mode,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] idx,
    input  logic [DATA_W-1:0] hi,
    input  logic [DATA_W-1:0] lo,
    input  logic              taken,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] npc
);

    localparam int EXT_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] idx_z;
    logic [ADDR_W-1:0] lo_z;
    logic [ADDR_W-1:0] lo_s;
    logic [ADDR_W-1:0] wide_off;
    logic [ADDR_W-1:0] follow;
    logic [ADDR_W-1:0] target;

    always_comb begin
        idx_z    = {{EXT_W{1'b0}}, idx};
        lo_z     = {{EXT_W{1'b0}}, lo};
        lo_s     = {{EXT_W{lo[DATA_W-1]}}, lo};
        wide_off = ADDR_W'({hi, lo});
        follow   = pc + ADDR_W'(1);
        target   = follow + lo_s;
        case (mode)
            MODE_IX0: begin
                ea  = idx_z;
                npc = pc;
            end
            MODE_IX8: begin
                ea  = idx_z + lo_z;
                npc = follow;
            end
            MODE_IX16: begin
                ea  = wide_off + idx_z;
                npc = pc + ADDR_W'(2);
            end
            default: begin
                ea  = target;
                npc = taken ? target : follow;
            end
        endcase
    end

endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
    import ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  ea_mode_e          mode,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] index_in,
    input  logic              taken_in,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] ea_out,
    output logic [ADDR_W-1:0] npc_out,
    output logic              done
);

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic [ADDR_W-1:0] npc;
        logic              done;
    } out_t;

    out_t q, d;

    logic              finish;
    ea_mode_e          lat_mode;
    logic [ADDR_W-1:0] lat_pc;
    logic [DATA_W-1:0] lat_idx;
    logic              lat_taken;
    logic [DATA_W-1:0] hi_byte;
    logic [ADDR_W-1:0] calc_ea;
    logic [ADDR_W-1:0] calc_npc;

    ea_fetch_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode      (mode),
        .pc_in     (pc_in),
        .index_in  (index_in),
        .taken_in  (taken_in),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .finish    (finish),
        .lat_mode  (lat_mode),
        .lat_pc    (lat_pc),
        .lat_idx   (lat_idx),
        .lat_taken (lat_taken),
        .hi_byte   (hi_byte)
    );

    ea_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_calc (
        .mode  (lat_mode),
        .pc    (lat_pc),
        .idx   (lat_idx),
        .hi    (hi_byte),
        .lo    (mem_rdata),
        .taken (lat_taken),
        .ea    (calc_ea),
        .npc   (calc_npc)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (finish) begin
            d.ea   = calc_ea;
            d.npc  = calc_npc;
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ea_out  = q.ea;
    assign npc_out = q.npc;
    assign done    = q.done;

endmodule

// File: rtl/ea_sequencer_chk.sv
module ea_sequencer_chk
    import ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic              done,
    input logic [ADDR_W-1:0] ea_out,
    input logic [ADDR_W-1:0] npc_out,
    input ea_mode_e          lat_mode,
    input logic [ADDR_W-1:0] lat_pc
);

    localparam logic [ADDR_W-1:0] PAGE0_MAX = ADDR_W'((1 << DATA_W) - 1);
    localparam logic [ADDR_W-1:0] IX8_MAX   = ADDR_W'(2 * ((1 << DATA_W) - 1));

    logic [1:0] rd_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || done) begin
            rd_cnt_q <= 2'd0;
        end else if (mem_rd) begin
            rd_cnt_q <= rd_cnt_q + 2'd1;
        end
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_read_gap_R6: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !done);

    assert_read_count_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (rd_cnt_q == operand_bytes(lat_mode)));

    assert_page0_R2: assert property (@(posedge clk) disable iff (rst)
        (done && lat_mode == MODE_IX0) |-> (ea_out <= PAGE0_MAX && npc_out == lat_pc));

    assert_ix8_range_R3: assert property (@(posedge clk) disable iff (rst)
        (done && lat_mode == MODE_IX8) |-> (ea_out <= IX8_MAX));

    assert_ix16_npc_R4: assert property (@(posedge clk) disable iff (rst)
        (done && lat_mode == MODE_IX16) |-> (npc_out == lat_pc + ADDR_W'(2)));

endmodule

bind ea_sequencer ea_sequencer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_rd   (mem_rd),
    .done     (done),
    .ea_out   (ea_out),
    .npc_out  (npc_out),
    .lat_mode (lat_mode),
    .lat_pc   (lat_pc)
);

// File: tb/ea_sequencer_test.sv
`timescale 1ns/1ps
module ea_sequencer_test;
    import ea_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    ea_mode_e    mode = MODE_IX0;
    logic [15:0] pc_in = '0;
    logic [7:0]  index_in = '0;
    logic        taken_in = 1'b0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] ea_out;
    logic [15:0] npc_out;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0]  mem [256];
    int          rd_cnt = 0;
    logic [15:0] rd_addr [4];

    always #2.5 clk = ~clk;

    ea_sequencer uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .pc_in(pc_in),
        .index_in(index_in), .taken_in(taken_in), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .ea_out(ea_out),
        .npc_out(npc_out), .done(done)
    );

    // Synchronous program memory model, one-cycle latency.
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[7:0]];
            if (rd_cnt < 4) rd_addr[rd_cnt] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    typedef struct packed {
        logic [1:0]  md;
        logic [15:0] pc;
        logic [7:0]  idx;
        logic        tk;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [15:0] ea;
        logic [15:0] npc;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'h1234, 8'h7F, 1'b0, 8'h00, 8'h00, 16'h007F, 16'h1234},
        '{2'd0, 16'h0000, 8'hFF, 1'b0, 8'h00, 8'h00, 16'h00FF, 16'h0000},
        '{2'd1, 16'h2000, 8'hFF, 1'b0, 8'hFF, 8'h00, 16'h01FE, 16'h2001},
        '{2'd1, 16'h2010, 8'h10, 1'b0, 8'h20, 8'h00, 16'h0030, 16'h2011},
        '{2'd2, 16'h3000, 8'h05, 1'b0, 8'h12, 8'h34, 16'h1239, 16'h3002},
        '{2'd2, 16'h30FE, 8'h02, 1'b0, 8'hFF, 8'hFF, 16'h0001, 16'h3100},
        '{2'd3, 16'h4000, 8'h00, 1'b1, 8'h10, 8'h00, 16'h4011, 16'h4011},
        '{2'd3, 16'h4000, 8'h00, 1'b1, 8'h80, 8'h00, 16'h3F81, 16'h3F81},
        '{2'd3, 16'h4000, 8'h00, 1'b0, 8'h80, 8'h00, 16'h3F81, 16'h4001},
        '{2'd3, 16'hFFFF, 8'h00, 1'b1, 8'h7F, 8'h00, 16'h007F, 16'h007F},
        '{2'd3, 16'h0005, 8'h00, 1'b1, 8'hF0, 8'h00, 16'hFFF6, 16'hFFF6}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int lat;
        int nb;
        string req;
        logic [15:0] ea_hold;
        logic [15:0] npc_hold;
        nb  = (v.md == 2'd0) ? 0 : (v.md == 2'd2) ? 2 : 1;
        req = (v.md == 2'd0) ? "R2" : (v.md == 2'd1) ? "R3" : (v.md == 2'd2) ? "R4" : "R5";
        mem[v.pc[7:0]]         = v.b0;
        mem[8'(v.pc[7:0] + 1)] = v.b1;
        rd_cnt   = 0;
        start    = 1'b1;
        mode     = ea_mode_e'(v.md);
        pc_in    = v.pc;
        index_in = v.idx;
        taken_in = v.tk;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 2 + nb, req, "done latency", lat, 2 + nb);
        chk(ea_out == v.ea, req, "ea", ea_out, v.ea);
        chk(npc_out == v.npc, req, "npc", npc_out, v.npc);
        chk(rd_cnt == nb, "R6", "read count", rd_cnt, nb);
        if (nb >= 1) chk(rd_addr[0] == v.pc, "R6", "first read address", rd_addr[0], v.pc);
        if (nb == 2) chk(rd_addr[1] == v.pc + 16'd1, "R6", "second read address", rd_addr[1], v.pc + 16'd1);
        ea_hold  = ea_out;
        npc_hold = npc_out;
        @(negedge clk);
        chk(done == 1'b0, "R7", "done pulse width", done, 0);
        chk(ea_out == ea_hold && npc_out == npc_hold, "R7", "result hold",
            {ea_out, npc_out}, {ea_hold, npc_hold});
    endtask

    initial begin
        int dn;
        repeat (3) @(negedge clk);
        chk(done == 0 && mem_rd == 0, "R1", "reset strobes", {done, mem_rd}, 0);
        chk(ea_out == 0 && npc_out == 0, "R1", "reset outputs", {ea_out, npc_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 0 && ea_out == 0 && npc_out == 0, "R1", "after reset",
            {done, ea_out}, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R8: a start during a busy operation is ignored.
        mem[8'h00] = 8'hAB;
        mem[8'h01] = 8'hCD;
        rd_cnt = 0;
        start = 1'b1; mode = MODE_IX16; pc_in = 16'h5000; index_in = 8'h01; taken_in = 1'b0;
        @(negedge clk);
        mode = MODE_IX0; pc_in = 16'h9999; index_in = 8'h33; taken_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R8", "no early done", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R8", "done on schedule", done, 1);
        chk(ea_out == 16'hABCE, "R8", "ea unaffected", ea_out, 16'hABCE);
        chk(npc_out == 16'h5002, "R8", "npc unaffected", npc_out, 16'h5002);
        dn = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (done) dn++;
        end
        chk(dn == 0, "R8", "extra done pulses", dn, 0);
        chk(rd_cnt == 2, "R8", "reads for one operation", rd_cnt, 2);

        // R9: reset in the middle of an operation.
        start = 1'b1; mode = MODE_IX16; pc_in = 16'h6000; index_in = 8'h00;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        dn = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (done) dn++;
        end
        chk(dn == 0, "R9", "done after abort", dn, 0);
        chk(ea_out == 0 && npc_out == 0, "R9", "outputs after abort", {ea_out, npc_out}, 0);
        chk(mem_rd == 0, "R9", "reads after abort", mem_rd, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule